// File: doc/BRIEF.md
# Per-Port Statistics Snapshot Unit

This block keeps the traffic statistics counters of a six-port switch and exposes them on a plain synchronous 16-bit register bus. Each port owns 33 event counters. Every counter advances by one on each cycle its event input is high. The counters are placed in two address regions, and each region has its own spacing between ports. Most counters are 32 bits wide. Three counters in each port are 64 bits wide.

The host does not read a live counter directly. It first writes to any word address of the counter; the data written is discarded. That write captures the counter into a 64-bit holding register. After a short busy window the captured value becomes visible, and the host reads it back one 16-bit word at a time. A control/status word reports the busy window and a clear-in-progress flag. The same word also accepts a command that clears every counter and commands that clear the counters of a single port.

Top module: `stat_snap_unit`

## Requirements
- R1: In the first region, counter c of port p sits at 0x1000 + 0x40*p + off. Counter 0 is at off 0 and counter 1 at off 4, both 4 words long. Counters 2 to 19 are at off 8+2*(c-2), 2 words each. Counter 20 is at off 44 and is 4 words long. Counters 21 to 28 are at off 48+2*(c-21), 2 words each.
- R2: In the second region, counter c (29 to 32) of port p sits at 0x1180 + 0x08*p + 2*(c-29). Each of these counters is 2 words long.
- R3: Bit p*33+c of `evt` adds one to counter c of port p on every clock edge where it is high. 4-word counters are 64 bits wide and 2-word counters are 32 bits wide.
- R4: A write to any word address of a counter captures that counter's value as it stood before that clock edge. The written data has no effect. An increment in the same cycle as the write reaches the live counter only.
- R5: After a capturing write, control bit 0 (busy) reads 1 for BUSY_CYC cycles. During that window, counter word reads return the previous capture. Reads return the new capture once busy has dropped.
- R6: Reading the address base+k of a counter returns bits 16k+15..16k of the capture. Reads return data one cycle after the read strobe.
- R7: Increments that arrive after a capture change the live counters but not the value being read back.
- R8: Writing 1 to control bit 2 at 0x11F0 zeroes every counter of every port at the next edge.
- R9: Writing 1 to control bit p+3 (bits 3 to 8 for ports 0 to 5) zeroes only the counters of port p.
- R10: Control bit 1 reads 1 only in the cycle that follows a clear command. An increment in the same cycle as a clear is lost.
- R11: The control word reads busy in bit 0 and clear-in-progress in bit 1, with all other bits 0. Writing bits 0 and 1 has no effect. Reads of unmapped addresses return 0.
- R12: After reset, all counters and the capture read 0, and busy and clear-in-progress are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 16 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after `bus_rd` |
| evt | input | NPORTS*33 | Per-counter increment events, bit p*33+c |

## Verification
The capture path is driven with short event bursts on counters at each distinct offset shape. These are a 4-word counter at the start of the first region, the 4-word counter at offset 44, the last 2-word slot of the first region, and slots in the second region at its first and last ports. A wrong region base, per-port stride or offset mapping therefore returns a count that belongs to a different counter. A single 70000-cycle burst pushes a value across the 16-bit boundary, which separates correct word ordering from swapped or truncated words. Directed cases place an increment in the same cycle as a capture and as a clear, read during and after the busy window, and clear one port while reading its neighbour. These cases separate "old value held" from "live value leaked" and "port cleared" from "all cleared".

// File: rtl/stat_snap_unit.sv
module stat_snap_unit #(
  parameter int NPORTS = 6,
  parameter int BUSY_CYC = 4,
  parameter logic [15:0] BASE_A = 16'h1000,
  parameter logic [15:0] BASE_B = 16'h1180,
  parameter logic [15:0] CTRL_ADDR = 16'h11F0,
  localparam int NCNT = 33
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_wr,
  input  logic                     bus_rd,
  input  logic [15:0]              bus_addr,
  input  logic [15:0]              bus_wdata,
  output logic [15:0]              bus_rdata,
  input  logic [NPORTS*NCNT-1:0]   evt
);
  localparam int STRIDE_A = 64;
  localparam int STRIDE_B = 8;
  localparam int PW = $clog2(NPORTS);
  localparam int CW = $clog2(NCNT);
  localparam int IW = $clog2(NPORTS*NCNT);
  localparam int BW = $clog2(BUSY_CYC+1);

  logic [15:0] offa, offb;
  logic in_a, in_b, hit, is_ctrl;
  logic [PW-1:0] dport;
  logic [CW-1:0] dcnt;
  logic [1:0] dword;
  logic [5:0] o;

  assign offa = bus_addr - BASE_A;
  assign offb = bus_addr - BASE_B;
  assign in_a = offa < 16'(NPORTS*STRIDE_A);
  assign in_b = offb < 16'(NPORTS*STRIDE_B);
  assign is_ctrl = bus_addr == CTRL_ADDR;
  assign o = offa[5:0];

  always_comb begin
    hit = 1'b0;
    dport = '0;
    dcnt = '0;
    dword = '0;
    if (in_a) begin
      hit = 1'b1;
      dport = PW'(offa >> 6);
      if (o < 6'd4) begin
        dcnt = CW'(0);
        dword = o[1:0];
      end else if (o < 6'd8) begin
        dcnt = CW'(1);
        dword = o[1:0];
      end else if (o < 6'd44) begin
        dcnt = CW'(o[5:1]) - CW'(2);
        dword = {1'b0, o[0]};
      end else if (o < 6'd48) begin
        dcnt = CW'(20);
        dword = o[1:0];
      end else begin
        dcnt = CW'(o[5:1]) - CW'(3);
        dword = {1'b0, o[0]};
      end
    end else if (in_b) begin
      hit = 1'b1;
      dport = PW'(offb >> 3);
      dcnt = CW'(29) + CW'(offb[2:1]);
      dword = {1'b0, offb[0]};
    end
  end

  logic clr_all;
  logic [NPORTS-1:0] clr_port;
  assign clr_all = bus_wr && is_ctrl && bus_wdata[2];
  assign clr_port = (bus_wr && is_ctrl) ? bus_wdata[3 +: NPORTS] : '0;

  logic [63:0] cval [NPORTS*NCNT];

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    for (genvar c = 0; c < NCNT; c++) begin : g_cnt
      localparam int W = (c == 0 || c == 1 || c == 20) ? 64 : 32;
      logic [W-1:0] q;
      always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else if (clr_all || clr_port[p]) q <= '0;
        else if (evt[p*NCNT+c]) q <= q + W'(1);
      end
      assign cval[p*NCNT+c] = 64'(q);
    end
  end

  logic lat_wr;
  logic [IW-1:0] lat_idx;
  logic [BW-1:0] busy_cnt;
  logic [63:0] pend, snap;
  logic rip, busy;

  assign lat_wr = bus_wr && hit;
  assign lat_idx = IW'(dport) * IW'(NCNT) + IW'(dcnt);
  assign busy = busy_cnt != '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_cnt <= '0;
      pend <= '0;
      snap <= '0;
      rip <= 1'b0;
    end else begin
      rip <= clr_all || (|clr_port);
      if (lat_wr) begin
        pend <= cval[lat_idx];
        busy_cnt <= BW'(BUSY_CYC);
      end else if (busy) begin
        busy_cnt <= busy_cnt - BW'(1);
        if (busy_cnt == BW'(1)) snap <= pend;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else if (bus_rd) begin
      if (is_ctrl) bus_rdata <= {14'b0, rip, busy};
      else if (hit) bus_rdata <= snap[{dword, 4'b0} +: 16];
      else bus_rdata <= '0;
    end
  end
endmodule

module stat_snap_unit_chk #(
  parameter int BUSY_CYC = 4,
  parameter logic [15:0] CTRL_ADDR = 16'h11F0
) (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic [15:0] bus_addr,
  input logic [15:0] bus_wdata,
  input logic [15:0] bus_rdata,
  input logic        lat_wr,
  input logic        busy,
  input logic        rip,
  input logic [63:0] snap,
  input logic [63:0] cnt0
);
  localparam int BW = $clog2(BUSY_CYC+1);
  logic [BW-1:0] win;

  always_ff @(posedge clk) begin
    if (!rst_n) win <= '0;
    else if (lat_wr) win <= BW'(BUSY_CYC);
    else if (win != '0) win <= win - BW'(1);
  end

  // R5
  latch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lat_wr |=> busy);

  // R5
  busy_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win != '0) |-> busy);

  // R7
  snap_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(snap) |-> $fell(busy));

  // R10
  rip_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == CTRL_ADDR && bus_wdata[2]) |=> rip);

  // R10
  rip_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rip |-> $past(bus_wr && bus_addr == CTRL_ADDR));

  // R11
  ctrl_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == CTRL_ADDR) |=> (bus_rdata[15:2] == 14'b0));

  // R8
  gclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == CTRL_ADDR && bus_wdata[2]) |=> (cnt0 == 64'b0));
endmodule

bind stat_snap_unit stat_snap_unit_chk #(.BUSY_CYC(BUSY_CYC), .CTRL_ADDR(CTRL_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .lat_wr(lat_wr), .busy(busy), .rip(rip), .snap(snap), .cnt0(cval[0])
);

// File: tb/stat_snap_unit_bench.sv
module stat_snap_unit_bench;
  localparam int NP = 6;
  localparam int NC = 33;
  localparam logic [15:0] CTRL = 16'h11F0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic bus_rd = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [NP*NC-1:0] evt = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  stat_snap_unit u_stat_snap_unit (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt(evt)
  );

  localparam logic [3:0] EV = 4'd1, WR = 4'd2, RD = 4'd3, ID = 4'd4;
  localparam int NV = 42;
  // op, addr/index, count/data, expected, requirement
  localparam logic [55:0] VEC [NV] = '{
    {EV, 16'h0000, 16'd5, 16'h0000, 4'd0},
    {WR, 16'h1000, 16'hFFFF, 16'h0000, 4'd0},
    {ID, 16'h0000, 16'd4, 16'h0000, 4'd0},
    {RD, 16'h1000, 16'h0000, 16'd5, 4'd1},
    {RD, 16'h1001, 16'h0000, 16'd0, 4'd6},
    {EV, 16'h0056, 16'd3, 16'h0000, 4'd0},
    {WR, 16'h10AC, 16'h0000, 16'h0000, 4'd0},
    {ID, 16'h0000, 16'd4, 16'h0000, 4'd0},
    {RD, 16'h10AC, 16'h0000, 16'd3, 4'd1},
    {EV, 16'h007F, 16'd4, 16'h0000, 4'd0},
    {WR, 16'h10FE, 16'h0000, 16'h0000, 4'd0},
    {ID, 16'h0000, 16'd4, 16'h0000, 4'd0},
    {RD, 16'h10FE, 16'h0000, 16'd4, 4'd1},
    {EV, 16'h00C5, 16'd7, 16'h0000, 4'd0},
    {WR, 16'h11AE, 16'h0000, 16'h0000, 4'd0},
    {ID, 16'h0000, 16'd4, 16'h0000, 4'd0},
    {RD, 16'h11AE, 16'h0000, 16'd7, 4'd2},
    {RD, 16'h11AF, 16'h0000, 16'd0, 4'd6},
    {EV, 16'h0026, 16'd2, 16'h0000, 4'd0},
    {WR, 16'h104F, 16'h0000, 16'h0000, 4'd0},
    {ID, 16'h0000, 16'd4, 16'h0000, 4'd0},
    {RD, 16'h104E, 16'h0000, 16'd2, 4'd4},
    {EV, 16'h001D, 16'd1, 16'h0000, 4'd0},
    {WR, 16'h1180, 16'h0000, 16'h0000, 4'd0},
    {ID, 16'h0000, 16'd4, 16'h0000, 4'd0},
    {RD, 16'h1180, 16'h0000, 16'd1, 4'd2},
    {RD, 16'h11F0, 16'h0000, 16'd0, 4'd11},
    {RD, 16'h2000, 16'h0000, 16'd0, 4'd11},
    {WR, 16'h11F0, 16'h0010, 16'h0000, 4'd0},
    {WR, 16'h104E, 16'h0000, 16'h0000, 4'd0},
    {ID, 16'h0000, 16'd4, 16'h0000, 4'd0},
    {RD, 16'h104E, 16'h0000, 16'd0, 4'd9},
    {WR, 16'h1000, 16'h0000, 16'h0000, 4'd0},
    {ID, 16'h0000, 16'd4, 16'h0000, 4'd0},
    {RD, 16'h1000, 16'h0000, 16'd5, 4'd9},
    {WR, 16'h11F0, 16'h0004, 16'h0000, 4'd0},
    {WR, 16'h11AE, 16'h0000, 16'h0000, 4'd0},
    {ID, 16'h0000, 16'd4, 16'h0000, 4'd0},
    {RD, 16'h11AE, 16'h0000, 16'd0, 4'd8},
    {WR, 16'h10AC, 16'h0000, 16'h0000, 4'd0},
    {ID, 16'h0000, 16'd4, 16'h0000, 4'd0},
    {RD, 16'h10AC, 16'h0000, 16'd0, 4'd8}
  };

  task automatic chk(input int r, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d: got %h expected %h", r, act, exp);
    end
  endtask

  task automatic do_wr(input logic [15:0] a, input logic [15:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic do_rd(input int r, input logic [15:0] a, input logic [15:0] exp);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    chk(r, bus_rdata, exp);
  endtask

  task automatic pulse(input int idx, input int n);
    evt[idx] = 1'b1;
    repeat (n) @(negedge clk);
    evt[idx] = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic snap_rd(input int r, input logic [15:0] a, input logic [15:0] exp);
    do_wr(a, 16'h0);
    idle(4);
    do_rd(r, a, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12: reset state
    do_rd(12, CTRL, 16'h0000);
    do_rd(12, 16'h1000, 16'h0000);
    do_rd(12, 16'h11AE, 16'h0000);

    // R1 R2 R4 R6 R8 R9 R11 through the vector table
    for (int i = 0; i < NV; i++) begin
      case (VEC[i][55:52])
        EV: pulse(int'(VEC[i][51:36]), int'(VEC[i][35:20]));
        WR: do_wr(VEC[i][51:36], VEC[i][35:20]);
        RD: do_rd(int'(VEC[i][3:0]), VEC[i][51:36], VEC[i][19:4]);
        default: idle(int'(VEC[i][35:20]));
      endcase
    end

    // R3: event counting, live counter p0 c0 starts at 0
    pulse(0, 3);
    snap_rd(3, 16'h1000, 16'd3);
    // R7: later increments leave the capture alone
    pulse(0, 2);
    do_rd(7, 16'h1000, 16'd3);
    // R5: busy window holds the old capture
    do_wr(16'h1000, 16'h0);
    do_rd(5, CTRL, 16'h0001);
    do_rd(5, 16'h1000, 16'd3);
    idle(2);
    do_rd(5, 16'h1000, 16'd5);
    do_rd(5, CTRL, 16'h0000);

    // R4: increment in the capture cycle goes to the live counter only
    evt[0] = 1'b1; bus_wr = 1'b1; bus_addr = 16'h1000;
    @(negedge clk);
    evt[0] = 1'b0; bus_wr = 1'b0;
    idle(4);
    do_rd(4, 16'h1000, 16'd5);
    snap_rd(3, 16'h1000, 16'd6);

    // R10: clear-in-progress flag for one cycle
    do_wr(CTRL, 16'h0004);
    do_rd(10, CTRL, 16'h0002);
    do_rd(10, CTRL, 16'h0000);

    // R10: increment together with a port clear is lost
    pulse(0, 3);
    evt[0] = 1'b1; bus_wr = 1'b1; bus_addr = CTRL; bus_wdata = 16'h0008;
    @(negedge clk);
    evt[0] = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    snap_rd(10, 16'h1000, 16'd0);

    // R11: control bits 0 and 1 are not writable
    pulse(0, 2);
    do_wr(CTRL, 16'h0003);
    do_rd(11, CTRL, 16'h0000);
    snap_rd(11, 16'h1000, 16'd2);

    // R6: word order across the 16-bit boundary, counter p0 c1
    pulse(1, 70000);
    snap_rd(6, 16'h1004, 16'h1170);
    do_rd(6, 16'h1005, 16'h0001);
    do_rd(6, 16'h1006, 16'h0000);
    do_rd(6, 16'h1007, 16'h0000);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule